// File: doc/BRIEF.md
# Mesh Grid Key Search Engine

The block searches a small list for a key using a square grid of processing cells, where each cell links only to its orthogonal neighbours. A front-end controller fills the grid with list entries, accepts a key and injects it at the corner cell at row 0, column 0. The key then travels one neighbour hop per clock, first along row 0 and then down every column. Once every cell holds the key, all cells compare in a single cycle. Each cell records its own row-major index on a match, or an all-ones sentinel otherwise.

The per-cell results are then merged by neighbour transfers only. The first phase folds each column upward into row 0. The second phase folds row 0 leftward into the corner cell. At each step only one rank of cells is active and the rest are masked idle. The corner then holds the smallest matching index, which is presented with a done flag.

List entries and the key enter through valid/ready streams. A transfer happens on a rising edge where both valid and ready are high. While ready is low, valid and data are ignored, and the source must hold an entry until it is taken. Start and done are plain control pins.

Top module: `mesh_search`

## Requirements
- R1: After reset, done, ld_ready and key_ready are all 0.
- R2: A start pulse is acted on only in the idle state or while done is high. A start pulse at any other time has no effect on loading progress or on a search in flight.
- R3: After an accepted start, ld_ready is high until exactly Q*Q entries have been transferred. The k-th transferred entry (k = 1 .. Q*Q) is given index k, which is row-major, row 0 first.
- R4: key_ready rises only once all Q*Q entries are loaded, and ld_ready and key_ready are never high together. A key transfer starts the search.
- R5: When done is high, result_idx equals the smallest index k whose entry equals the key.
- R6: When no entry equals the key, result_idx is all ones at its width (5'h1F for the default size).
- R7: done rises exactly 4*(Q-1)+1 clock cycles after the edge on which the key is transferred (13 for Q = 4). This count is 2(Q-1) broadcast hops, one compare and 2(Q-1) reduction steps.
- R8: done stays high, and result_idx stays constant, until the next start. A start while done is high drops done and reopens loading on the following cycle.
- R9: ld_valid or key_valid asserted while the matching ready is low transfers nothing. In particular, a key offered during loading is not taken before the list is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new load-and-search sequence |
| ld_valid | input | 1 | List entry offered |
| ld_ready | output | 1 | Engine accepts a list entry |
| ld_data | input | DW | List entry value |
| key_valid | input | 1 | Search key offered |
| key_ready | output | 1 | Engine accepts the key |
| key_data | input | DW | Search key value |
| done | output | 1 | Result valid, held until next start |
| result_idx | output | IW | Smallest matching index, or all-ones if none |

## Verification
A cell with a wrong mask step or a wrong neighbour link leaves a stale key or a stale partial minimum in the grid. That fault appears at result_idx the moment done rises, 13 cycles after the key transfer. A fault in the controller's state or load count changes when ld_ready, key_ready or done toggle, and so shows up within one cycle of the diverging transfer. For that reason the ready and done flags are compared against an independent model on every clock. The result is checked with keys that match several cells, only the first or last cell, or no cell at all.

// File: rtl/mesh_search_pkg.sv
package mesh_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_BCAST,
    ST_CMP,
    ST_COLRED,
    ST_ROWRED,
    ST_DONE
  } phase_t;

  // Broadcast step on which a cell captures the key: row 0 along the row,
  // other rows after the row-0 sweep completes, down each column.
  function automatic int arrive_step(input int row, input int col, input int q);
    return (row == 0) ? col : (q - 1 + row);
  endfunction

endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
  import mesh_search_pkg::*;
#(
  parameter int Q  = 4,
  parameter int CW = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_valid,
  input  logic          key_valid,
  output phase_t        phase,
  output logic [SW-1:0] step,
  output logic [CW-1:0] ld_cnt,
  output logic          ld_ready,
  output logic          key_ready,
  output logic          ld_fire,
  output logic          key_fire,
  output logic          done
);
  localparam int N = Q * Q;
  localparam logic [CW-1:0] CNT_FULL = CW'(N);
  localparam logic [SW-1:0] BC_LAST  = SW'(2 * (Q - 1));
  localparam logic [SW-1:0] RED_LAST = SW'(Q - 1);

  assign ld_ready  = (phase == ST_LOAD) && (ld_cnt < CNT_FULL);
  assign key_ready = (phase == ST_LOAD) && (ld_cnt == CNT_FULL);
  assign ld_fire   = ld_ready && ld_valid;
  assign key_fire  = key_ready && key_valid;
  assign done      = (phase == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= ST_IDLE;
      step   <= '0;
      ld_cnt <= '0;
    end else begin
      unique case (phase)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            phase  <= ST_LOAD;
            ld_cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (ld_fire) ld_cnt <= ld_cnt + 1'b1;
          if (key_fire) begin
            phase <= ST_BCAST;
            step  <= SW'(1);
          end
        end
        ST_BCAST: begin
          if (step == BC_LAST) phase <= ST_CMP;
          else step <= step + 1'b1;
        end
        ST_CMP: begin
          phase <= ST_COLRED;
          step  <= SW'(1);
        end
        ST_COLRED: begin
          if (step == RED_LAST) begin
            phase <= ST_ROWRED;
            step  <= SW'(1);
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_ROWRED: begin
          if (step == RED_LAST) phase <= ST_DONE;
          else step <= step + 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assert_ready_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ready && key_ready));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt <= CNT_FULL);

  assert_key_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_fire |=> (phase == ST_BCAST));

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_BCAST || phase == ST_CMP || phase == ST_COLRED) |=> (phase != ST_LOAD));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/mesh_pe.sv
module mesh_pe
  import mesh_search_pkg::*;
#(
  parameter int ROW = 0,
  parameter int COL = 0,
  parameter int Q   = 4,
  parameter int DW  = 8,
  parameter int IW  = 5,
  parameter int SW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_val,
  input  logic          inj_en,
  input  logic          bc_en,
  input  logic          cmp_en,
  input  logic          colred_en,
  input  logic          rowred_en,
  input  logic [SW-1:0] step,
  input  logic [DW-1:0] x_nb,
  input  logic [IW-1:0] res_nb,
  input  logic [IW-1:0] res_rt,
  output logic [DW-1:0] x_q,
  output logic [IW-1:0] res_q
);
  localparam int ARR = arrive_step(ROW, COL, Q);
  localparam logic [IW-1:0] IDX  = IW'(ROW * Q + COL + 1);
  localparam logic [IW-1:0] SENT = '1;
  localparam bit HAS_BELOW = (ROW < Q - 1);
  localparam bit HAS_RIGHT = (ROW == 0) && (COL < Q - 1);
  localparam logic [SW-1:0] COL_STEP = SW'(Q - 1 - ROW);
  localparam logic [SW-1:0] ROW_STEP = SW'(Q - 1 - COL);

  logic [DW-1:0] entry_q;
  logic x_en, col_act, row_act;

  assign x_en    = inj_en || (bc_en && step == SW'(ARR));
  assign col_act = HAS_BELOW && colred_en && (step == COL_STEP);
  assign row_act = HAS_RIGHT && rowred_en && (step == ROW_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      x_q     <= '0;
      res_q   <= SENT;
    end else begin
      if (ld_en) entry_q <= ld_val;
      if (x_en) x_q <= x_nb;
      if (cmp_en) res_q <= (entry_q == x_q) ? IDX : SENT;
      else if (col_act) res_q <= (res_nb < res_q) ? res_nb : res_q;
      else if (row_act) res_q <= (res_rt < res_q) ? res_rt : res_q;
    end
  end

  assert_red_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (colred_en || rowred_en) |=> (res_q <= $past(res_q)));

endmodule

// File: rtl/mesh_search.sv
module mesh_search
  import mesh_search_pkg::*;
#(
  parameter int Q  = 4,
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       ld_valid,
  output logic                       ld_ready,
  input  logic [DW-1:0]              ld_data,
  input  logic                       key_valid,
  output logic                       key_ready,
  input  logic [DW-1:0]              key_data,
  output logic                       done,
  output logic [$clog2(Q*Q+1)-1:0]   result_idx
);
  localparam int N  = Q * Q;
  localparam int IW = $clog2(N + 1);
  localparam int CW = $clog2(N + 1);
  localparam int SW = $clog2(2 * Q);
  localparam logic [IW-1:0] SENT = '1;

  phase_t        phase;
  logic [SW-1:0] step;
  logic [CW-1:0] ld_cnt;
  logic          ld_fire, key_fire;

  logic [DW-1:0] x_w   [N];
  logic [IW-1:0] res_w [N];

  mesh_ctrl #(.Q(Q), .CW(CW), .SW(SW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ld_valid  (ld_valid),
    .key_valid (key_valid),
    .phase     (phase),
    .step      (step),
    .ld_cnt    (ld_cnt),
    .ld_ready  (ld_ready),
    .key_ready (key_ready),
    .ld_fire   (ld_fire),
    .key_fire  (key_fire),
    .done      (done)
  );

  logic bc_en, cmp_en, colred_en, rowred_en;
  assign bc_en     = (phase == ST_BCAST);
  assign cmp_en    = (phase == ST_CMP);
  assign colred_en = (phase == ST_COLRED);
  assign rowred_en = (phase == ST_ROWRED);

  for (genvar r = 0; r < Q; r++) begin : g_row
    for (genvar c = 0; c < Q; c++) begin : g_col
      localparam int K = r * Q + c;
      logic [DW-1:0] x_src;
      logic [IW-1:0] below, right;
      logic          inj, ld_sel;

      if (r == 0 && c == 0) begin : g_corner
        assign x_src = key_data;
        assign inj   = key_fire;
      end else if (r == 0) begin : g_top
        assign x_src = x_w[K-1];
        assign inj   = 1'b0;
      end else begin : g_inner
        assign x_src = x_w[K-Q];
        assign inj   = 1'b0;
      end

      if (r < Q - 1) begin : g_has_below
        assign below = res_w[K+Q];
      end else begin : g_no_below
        assign below = SENT;
      end

      if (c < Q - 1) begin : g_has_right
        assign right = res_w[K+1];
      end else begin : g_no_right
        assign right = SENT;
      end

      assign ld_sel = ld_fire && (ld_cnt == CW'(K));

      mesh_pe #(
        .ROW(r), .COL(c), .Q(Q), .DW(DW), .IW(IW), .SW(SW)
      ) u_pe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_sel),
        .ld_val    (ld_data),
        .inj_en    (inj),
        .bc_en     (bc_en),
        .cmp_en    (cmp_en),
        .colred_en (colred_en),
        .rowred_en (rowred_en),
        .step      (step),
        .x_nb      (x_src),
        .res_nb    (below),
        .res_rt    (right),
        .x_q       (x_w[K]),
        .res_q     (res_w[K])
      );

      assert_bcast_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |-> (x_w[K] == x_w[0]));
    end
  end

  assign result_idx = res_w[0];

  assert_result_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result_idx == SENT || (result_idx >= IW'(1) && result_idx <= IW'(N))));

endmodule

// File: tb/mesh_search_bench.sv
module mesh_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q    = 4;
  localparam int DW   = 8;
  localparam int N    = Q * Q;
  localparam int IW   = 5;
  localparam int SENT = 31;
  localparam int LAT  = 4 * (Q - 1) + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic ld_valid = 0, key_valid = 0;
  logic [DW-1:0] ld_data = '0, key_data = '0;
  logic ld_ready, key_ready, done;
  logic [IW-1:0] result_idx;

  mesh_search #(.Q(Q), .DW(DW)) u_mesh_search (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .key_valid(key_valid), .key_ready(key_ready), .key_data(key_data),
    .done(done), .result_idx(result_idx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 load, 2 searching, 3 done
  int mst = 0, mcnt = 0, mtimer = 0, mres = SENT;
  int mlist[N];

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mcnt = 0; mtimer = 0;
    end else begin
      case (mst)
        0, 3: if (start) begin mst = 1; mcnt = 0; end
        1: begin
          if (mcnt < N && ld_valid) begin
            mlist[mcnt] = int'(ld_data);
            mcnt++;
          end else if (mcnt == N && key_valid) begin
            mres = SENT;
            for (int k = N - 1; k >= 0; k--)
              if (mlist[k] == int'(key_data)) mres = k + 1;
            mtimer = LAT;
            mst = 2;
          end
        end
        2: begin
          mtimer--;
          if (mtimer == 0) mst = 3;
        end
        default: mst = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(ld_ready == (mst == 1 && mcnt < N), "R3 ld_ready", int'(ld_ready), int'(mst == 1 && mcnt < N));
      check(key_ready == (mst == 1 && mcnt == N), "R4 key_ready", int'(key_ready), int'(mst == 1 && mcnt == N));
      check(done == (mst == 3), "R7 done timing", int'(done), int'(mst == 3));
      if (mst == 3)
        check(int'(result_idx) == mres, (mres == SENT) ? "R6 result" : "R5 result", int'(result_idx), mres);
    end
  end

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 100000);
      summary_and_end();
    end
  end

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send_ld(input int d);
    bit fired = 0;
    ld_valid = 1;
    ld_data  = DW'(d);
    while (!fired) begin
      fired = ld_ready;
      @(negedge clk);
    end
    ld_valid = 0;
  endtask

  task automatic load_list(input int v[N], input bit gaps, input bit mid_start);
    for (int k = 0; k < N; k++) begin
      if (gaps && (k % 3 == 1)) @(negedge clk);
      if (mid_start && k == 8) begin
        start = 1;
        send_ld(v[k]);
        start = 0;
      end else begin
        send_ld(v[k]);
      end
    end
  endtask

  // Offers the key, then counts cycles to done and checks the result.
  task automatic search(input int key, input int v[N], input bit start_mid_run);
    bit fired = 0;
    int n = 0;
    int exp = SENT;
    for (int k = N - 1; k >= 0; k--) if (v[k] == key) exp = k + 1;
    key_valid = 1;
    key_data  = DW'(key);
    while (!fired) begin
      fired = key_ready;
      @(negedge clk);
    end
    key_valid = 0;
    while (!done && n < 100) begin
      start = (start_mid_run && n == 4);
      @(negedge clk);
      n++;
    end
    start = 0;
    check(n == LAT, "R7 latency", n, LAT);
    if (exp == SENT) check(int'(result_idx) == SENT, "R6 not found", int'(result_idx), SENT);
    else check(int'(result_idx) == exp, "R5 smallest match", int'(result_idx), exp);
  endtask

  initial begin
    int v[N];
    int hold_res;
    repeat (3) @(negedge clk);
    check(done == 0, "R1 done reset", int'(done), 0);
    check(ld_ready == 0, "R1 ld_ready reset", int'(ld_ready), 0);
    check(key_ready == 0, "R1 key_ready reset", int'(key_ready), 0);
    rst_n = 1;
    @(negedge clk);

    // Several matches: key 5 at indices 6, 9, 11, 14
    for (int k = 0; k < N; k++) v[k] = 20 + k;
    v[5] = 5; v[8] = 5; v[10] = 5; v[13] = 5;
    pulse_start();
    load_list(v, 1'b0, 1'b0);
    search(5, v, 1'b0);

    // R8: done holds, result stable; R9: ld_valid with no ready is ignored
    hold_res = int'(result_idx);
    ld_valid = 1; ld_data = 8'd99;
    repeat (5) @(negedge clk);
    ld_valid = 0;
    check(done == 1, "R8 done held", int'(done), 1);
    check(int'(result_idx) == hold_res, "R8 result stable", int'(result_idx), hold_res);
    check(ld_ready == 0, "R9 no load while done", int'(ld_ready), 0);

    // Same list reloaded, no match; start pulsed mid-run is ignored (R2)
    pulse_start();
    check(done == 0 && ld_ready == 1, "R8 restart reopens load", int'(done), 0);
    load_list(v, 1'b1, 1'b0);
    search(77, v, 1'b1);

    // All equal: first cell wins
    for (int k = 0; k < N; k++) v[k] = 7;
    pulse_start();
    load_list(v, 1'b0, 1'b0);
    search(7, v, 1'b0);

    // Only last cell matches; key offered early (R9); start mid-load (R2)
    for (int k = 0; k < N; k++) v[k] = k;
    v[N-1] = 200;
    pulse_start();
    key_valid = 1; key_data = 8'd200;
    for (int k = 0; k < N - 1; k++) send_ld(v[k]);
    check(key_ready == 0 && done == 0, "R9 key held off before full", int'(key_ready), 0);
    start = 1;
    @(negedge clk);
    start = 0;
    check(ld_ready == 1, "R2 mid-load start ignored", int'(ld_ready), 1);
    send_ld(v[N-1]);
    search(200, v, 1'b0);

    // Only first cell matches, loaded with gaps
    for (int k = 0; k < N; k++) v[k] = 100 - k;
    pulse_start();
    load_list(v, 1'b1, 1'b1);
    search(100, v, 1'b0);

    repeat (2) @(negedge clk);
    summary_and_end();
  end

endmodule